// File: doc/BRIEF.md
# Interrupt Flag and Priority Controller

This block gathers interrupt requests from several sources and keeps each one as a pending flag. Each flag is gated twice: once by an enable bit for its own source, and once by a single global enable. From the requests that pass both gates, a fixed-priority arbiter picks one and presents its vector number to the CPU sequencer, together with a valid strobe. When the sequencer accepts that vector, the controller clears the flag it serviced and drops the global enable. A return strobe from the sequencer sets the global enable again.

Source 0 is an external pin. The pin goes through a two-flop synchronizer and then a sense unit that offers four trigger modes. In the low-level mode no flag is stored, so the request simply follows the synchronized pin. The other sources are single-cycle request pulses from on-chip logic. Software reaches three 8-bit registers over a small register bus: the enables, the flags (write-one-to-clear) and a control register that holds the sense mode and the global enable.

Top module: `irqc_top`

## Requirements
- R1: After reset, the enable register (address 0), the flag register (address 1) and the control register (address 2) all read 0x00, and irq_valid_o is low.
- R2: A request pulse sets its flag even while its enable bit is clear. With no clear applied, the flag then keeps its value.
- R3: While the global enable (control bit 7) is clear, irq_valid_o stays low and flags keep collecting. Once it is set, enabled pending sources are presented one at a time, and the lowest vector number is presented first.
- R4: An acknowledge while irq_valid_o is high clears the flag of the presented source and clears the global enable. A return strobe sets the global enable.
- R5: Writing address 1 clears every flag whose written bit is 1. Flags whose written bit is 0 are left unchanged.
- R6: Control bits [1:0] choose the pin sense. 01 flags either edge, 10 flags a falling edge only, and 11 flags a rising edge only. An edge that the selected mode does not match sets no flag.
- R7: In sense mode 00 (low level), the pin stores no flag: flag bit 6 reads 0. The request is present only while the synchronized pin is low.
- R8: In the enable and flag registers, bit 6 belongs to the external pin and bit j belongs to on-chip source j+1. Bit 7 and the unused bits always read 0.
- R9: The external pin has vector 1, and on-chip source k has vector k+1.
- R10: If a request and a clear hit the same flag in the same cycle, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ext_pin_i | input | 1 | External interrupt pin (asynchronous) |
| src_req_i | input | NUM_SRC-1 | Single-cycle request pulses from on-chip sources 1..NUM_SRC-1 |
| bus_wr_i | input | 1 | Register write strobe |
| bus_addr_i | input | 2 | Register address: 0 enables, 1 flags, 2 control |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data for bus_addr_i (combinational) |
| irq_valid_o | output | 1 | A qualified request is being presented |
| irq_vector_o | output | $clog2(NUM_SRC+1) | Vector number of the presented source |
| cpu_ack_i | input | 1 | The sequencer accepts the presented vector |
| cpu_ret_i | input | 1 | Return from the handler; sets the global enable |

## Verification
The bench builds the block with its default NUM_SRC=4: one external pin and three on-chip sources, which gives vectors 1 to 4. This is enough to line up a three-deep priority sequence, with acknowledge and return alternating, and to see that the external pin outranks every on-chip source. It also leaves flag bits 3 to 5 unused, so they can be checked to read zero. With the default two synchronizer stages, the bench can work out exactly how many cycles pass between a pin change and the flag or request that follows it.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

  typedef enum logic [1:0] {
    SENSE_LOW  = 2'b00,
    SENSE_ANY  = 2'b01,
    SENSE_FALL = 2'b10,
    SENSE_RISE = 2'b11
  } sense_e;

  localparam int REG_W    = 8;
  localparam int EXT_BIT  = 6;
  localparam int GIE_BIT  = 7;
  localparam logic [1:0] ADDR_MASK = 2'd0;
  localparam logic [1:0] ADDR_FLAG = 2'd1;
  localparam logic [1:0] ADDR_CTRL = 2'd2;

  // Tell whether a synchronized pin transition matches the selected sense
  function automatic logic edge_hit(sense_e mode, logic prev, logic cur);
    logic hit;
    case (mode)
      SENSE_ANY:  hit = prev ^ cur;
      SENSE_FALL: hit = prev & ~cur;
      SENSE_RISE: hit = ~prev & cur;
      default:    hit = 1'b0;
    endcase
    return hit;
  endfunction

endpackage

// File: rtl/irqc_pin_sense.sv
module irqc_pin_sense
  import irqc_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   pin_i,
  input  sense_e mode_i,
  output logic   edge_o,
  output logic   level_req_o
);

  localparam int TOP = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;

  // The synchronizer resets to the idle-high pin level, so leaving reset
  // does not look like an edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '1;
      prev_q <= 1'b1;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], pin_i};
      prev_q <= sync_q[TOP];
    end
  end

  assign edge_o      = edge_hit(mode_i, prev_q, sync_q[TOP]);
  assign level_req_o = (mode_i == SENSE_LOW) && !sync_q[TOP];

endmodule

// File: rtl/irqc_flag_bank.sv
module irqc_flag_bank #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] flag_o
);

  logic [N-1:0] flag_q;

  // A set in the same cycle beats a clear, so no new request is lost.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= '0;
    else        flag_q <= (flag_q & ~clr_i) | set_i;
  end

  assign flag_o = flag_q;

endmodule

// File: rtl/irqc_arbiter.sv
module irqc_arbiter #(
  parameter int N     = 4,
  parameter int VEC_W = 3
) (
  input  logic [N-1:0]     active_i,
  input  logic             gie_i,
  output logic             valid_o,
  output logic [VEC_W-1:0] vec_o,
  output logic [N-1:0]     grant_o
);

  // Fixed priority: the lowest source index, and so the lowest vector, wins.
  function automatic int first_index(logic [N-1:0] v);
    int idx;
    idx = 0;
    for (int i = N - 1; i >= 0; i--) begin
      if (v[i]) idx = i;
    end
    return idx;
  endfunction

  int win;

  always_comb begin
    win     = first_index(active_i);
    valid_o = gie_i && (|active_i);
    vec_o   = valid_o ? VEC_W'(win + 1) : '0;
    grant_o = '0;
    if (valid_o) grant_o[win] = 1'b1;
  end

endmodule

// File: rtl/irqc_top.sv
module irqc_top
  import irqc_pkg::*;
#(
  parameter int NUM_SRC     = 4,
  parameter int SYNC_STAGES = 2,
  localparam int NUM_INT    = NUM_SRC - 1,
  localparam int VEC_W      = $clog2(NUM_SRC + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ext_pin_i,
  input  logic [NUM_INT-1:0] src_req_i,
  input  logic               bus_wr_i,
  input  logic [1:0]         bus_addr_i,
  input  logic [7:0]         bus_wdata_i,
  output logic [7:0]         bus_rdata_o,
  output logic               irq_valid_o,
  output logic [VEC_W-1:0]   irq_vector_o,
  input  logic               cpu_ack_i,
  input  logic               cpu_ret_i
);

  // Source index 0 is the pin and sits at register bit 6.
  // Source k >= 1 sits at register bit k-1.
  function automatic logic [REG_W-1:0] to_reg(logic [NUM_SRC-1:0] v);
    logic [REG_W-1:0] r;
    r          = '0;
    r[EXT_BIT] = v[0];
    for (int j = 1; j < NUM_SRC; j++) r[j-1] = v[j];
    return r;
  endfunction

  function automatic logic [NUM_SRC-1:0] from_reg(logic [REG_W-1:0] r);
    logic [NUM_SRC-1:0] v;
    v[0] = r[EXT_BIT];
    for (int j = 1; j < NUM_SRC; j++) v[j] = r[j-1];
    return v;
  endfunction

  logic [NUM_SRC-1:0] mask_q;
  logic [NUM_SRC-1:0] flag_q;
  logic [NUM_SRC-1:0] flag_set;
  logic [NUM_SRC-1:0] flag_clr;
  logic [NUM_SRC-1:0] pending;
  logic [NUM_SRC-1:0] active;
  logic [NUM_SRC-1:0] grant_w;
  sense_e             mode_q;
  logic               gie_q;
  logic               pin_edge;
  logic               pin_level;
  logic               ack_fire;
  logic               wr_mask;
  logic               wr_flag;
  logic               wr_ctrl;

  assign wr_mask  = bus_wr_i && (bus_addr_i == ADDR_MASK);
  assign wr_flag  = bus_wr_i && (bus_addr_i == ADDR_FLAG);
  assign wr_ctrl  = bus_wr_i && (bus_addr_i == ADDR_CTRL);
  assign ack_fire = cpu_ack_i && irq_valid_o;

  irqc_pin_sense #(.SYNC_STAGES(SYNC_STAGES)) u_sense (
    .clk         (clk),
    .rst_n       (rst_n),
    .pin_i       (ext_pin_i),
    .mode_i      (mode_q),
    .edge_o      (pin_edge),
    .level_req_o (pin_level)
  );

  // Flag set and clear events, kept as named wires for the checker.
  always_comb begin
    flag_set    = '0;
    flag_set[0] = pin_edge && (mode_q != SENSE_LOW);
    for (int k = 1; k < NUM_SRC; k++) flag_set[k] = src_req_i[k-1];
    flag_clr = (wr_flag ? from_reg(bus_wdata_i) : '0)
             | (ack_fire ? grant_w : '0);
    if (mode_q == SENSE_LOW) flag_clr[0] = 1'b1;
  end

  irqc_flag_bank #(.N(NUM_SRC)) u_flags (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_i  (flag_set),
    .clr_i  (flag_clr),
    .flag_o (flag_q)
  );

  always_comb begin
    pending    = flag_q;
    pending[0] = (mode_q == SENSE_LOW) ? pin_level : flag_q[0];
    active     = pending & mask_q;
  end

  irqc_arbiter #(.N(NUM_SRC), .VEC_W(VEC_W)) u_arb (
    .active_i (active),
    .gie_i    (gie_q),
    .valid_o  (irq_valid_o),
    .vec_o    (irq_vector_o),
    .grant_o  (grant_w)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
      mode_q <= SENSE_LOW;
      gie_q  <= 1'b0;
    end else begin
      if (wr_mask) mask_q <= from_reg(bus_wdata_i);
      if (wr_ctrl) mode_q <= sense_e'(bus_wdata_i[1:0]);
      if (ack_fire)       gie_q <= 1'b0;
      else if (wr_ctrl)   gie_q <= bus_wdata_i[GIE_BIT];
      else if (cpu_ret_i) gie_q <= 1'b1;
    end
  end

  always_comb begin
    case (bus_addr_i)
      ADDR_MASK: bus_rdata_o = to_reg(mask_q);
      ADDR_FLAG: bus_rdata_o = to_reg(flag_q);
      ADDR_CTRL: bus_rdata_o = {gie_q, 5'b0, mode_q};
      default:   bus_rdata_o = '0;
    endcase
  end

endmodule

// File: rtl/irqc_checks.sv
module irqc_checks #(
  parameter int NUM_SRC = 4,
  parameter int VEC_W   = 3
) (
  input logic               clk,
  input logic               rst_n,
  input logic               irq_valid,
  input logic [VEC_W-1:0]   irq_vector,
  input logic               gie,
  input logic               ack_fire,
  input logic [1:0]         mode,
  input logic [1:0]         bus_addr,
  input logic [7:0]         rdata,
  input logic [NUM_SRC-1:0] flags,
  input logic [NUM_SRC-1:0] set_v,
  input logic [NUM_SRC-1:0] clr_v,
  input logic [NUM_SRC-1:0] grant
);

  AST_VALID_NEEDS_GIE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid |-> gie); // R3

  AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant)); // R3

  AST_VECTOR_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid |-> (int'(irq_vector) >= 1 && int'(irq_vector) <= NUM_SRC)); // R9

  AST_ACK_DROPS_GIE: assert property (@(posedge clk) disable iff (!rst_n)
    ack_fire |=> !gie); // R4

  AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr != 2'd2) |-> !rdata[7]); // R8

  AST_LEVEL_NO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b00) |=> !flags[0]); // R7

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_flag
    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      set_v[i] |=> flags[i]); // R10

    AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_v[i] && !set_v[i]) |=> !flags[i]); // R5

    AST_FLAG_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr_v[i] && !set_v[i]) |=> $stable(flags[i])); // R2
  end

endmodule

bind irqc_top irqc_checks #(.NUM_SRC(NUM_SRC), .VEC_W(VEC_W)) u_checks (
  .clk        (clk),
  .rst_n      (rst_n),
  .irq_valid  (irq_valid_o),
  .irq_vector (irq_vector_o),
  .gie        (gie_q),
  .ack_fire   (ack_fire),
  .mode       (mode_q),
  .bus_addr   (bus_addr_i),
  .rdata      (bus_rdata_o),
  .flags      (flag_q),
  .set_v      (flag_set),
  .clr_v      (flag_clr),
  .grant      (grant_w)
);

// File: tb/tb_irqc_top.sv
module tb_irqc_top;

  localparam int NSRC = 4;
  localparam int VW   = $clog2(NSRC + 1);

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            pin = 1'b1;
  logic [NSRC-2:0] src_req = '0;
  logic            bus_wr = 1'b0;
  logic [1:0]      bus_addr = '0;
  logic [7:0]      bus_wdata = '0;
  logic [7:0]      bus_rdata;
  logic            irq_valid;
  logic [VW-1:0]   irq_vector;
  logic            ack = 1'b0;
  logic            ret = 1'b0;

  int errors = 0;
  int checks = 0;

  always #4 clk = ~clk;

  irqc_top #(.NUM_SRC(NSRC)) dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .ext_pin_i    (pin),
    .src_req_i    (src_req),
    .bus_wr_i     (bus_wr),
    .bus_addr_i   (bus_addr),
    .bus_wdata_i  (bus_wdata),
    .bus_rdata_o  (bus_rdata),
    .irq_valid_o  (irq_valid),
    .irq_vector_o (irq_vector),
    .cpu_ack_i    (cpu_ack_wire()),
    .cpu_ret_i    (ret)
  );

  function automatic logic cpu_ack_wire();
    return ack;
  endfunction

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic pulse(input logic [NSRC-2:0] v);
    @(negedge clk); src_req = v;
    @(negedge clk); src_req = '0;
  endtask

  task automatic do_ack();
    @(negedge clk); ack = 1'b1;
    @(negedge clk); ack = 1'b0;
  endtask

  task automatic do_ret();
    @(negedge clk); ret = 1'b1;
    @(negedge clk); ret = 1'b0;
  endtask

  task automatic set_pin(input logic v);
    @(negedge clk); pin = v;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [7:0] d;
    rd(2'd0, d); check("R1", "mask after reset", d, 8'h00);
    rd(2'd1, d); check("R1", "flags after reset", d, 8'h00);
    rd(2'd2, d); check("R1", "ctrl after reset", d, 8'h00);
    check("R1", "valid after reset", irq_valid, 0);
  endtask

  task automatic t_masked_latch();
    logic [7:0] d;
    pulse(3'b001);
    repeat (3) @(negedge clk);
    rd(2'd1, d); check("R2", "masked flag kept", d, 8'h01);
    check("R2", "no valid while masked", irq_valid, 0);
    wr(2'd1, 8'h00);
    rd(2'd1, d); check("R5", "zero write leaves flag", d, 8'h01);
    wr(2'd1, 8'h01);
    rd(2'd1, d); check("R5", "one write clears flag", d, 8'h00);
  endtask

  task automatic t_priority();
    logic [7:0] d;
    wr(2'd0, 8'h07);
    pulse(3'b111);
    rd(2'd1, d); check("R3", "three flags latched", d, 8'h07);
    check("R3", "no valid with gie clear", irq_valid, 0);
    wr(2'd2, 8'h80);
    check("R3", "valid after gie set", irq_valid, 1);
    check("R9", "first vector", irq_vector, 2);
    do_ack();
    rd(2'd1, d); check("R4", "ack clears first flag", d, 8'h06);
    rd(2'd2, d); check("R4", "ack drops gie", d, 8'h00);
    check("R4", "valid low after ack", irq_valid, 0);
    do_ret();
    check("R3", "second vector", irq_vector, 3);
    do_ack();
    do_ret();
    check("R3", "third vector", irq_vector, 4);
    do_ack();
    rd(2'd1, d); check("R4", "all flags served", d, 8'h00);
  endtask

  task automatic t_edges();
    logic [7:0] d;
    wr(2'd0, 8'h40);
    wr(2'd2, 8'h02);
    set_pin(1'b0);
    rd(2'd1, d); check("R6", "falling mode, falling edge", d, 8'h40);
    wr(2'd1, 8'h40);
    set_pin(1'b1);
    rd(2'd1, d); check("R6", "falling mode, rising edge", d, 8'h00);
    wr(2'd2, 8'h03);
    set_pin(1'b0);
    rd(2'd1, d); check("R6", "rising mode, falling edge", d, 8'h00);
    set_pin(1'b1);
    rd(2'd1, d); check("R6", "rising mode, rising edge", d, 8'h40);
    wr(2'd1, 8'h40);
    wr(2'd2, 8'h01);
    set_pin(1'b0);
    rd(2'd1, d); check("R6", "any mode, falling edge", d, 8'h40);
    wr(2'd1, 8'h40);
    set_pin(1'b1);
    rd(2'd1, d); check("R6", "any mode, rising edge", d, 8'h40);
    wr(2'd2, 8'h81);
    check("R9", "pin valid", irq_valid, 1);
    check("R9", "pin vector", irq_vector, 1);
    do_ack();
    rd(2'd1, d); check("R4", "ack clears pin flag", d, 8'h00);
  endtask

  task automatic t_level();
    logic [7:0] d;
    wr(2'd2, 8'h80);
    check("R7", "idle-high pin no request", irq_valid, 0);
    set_pin(1'b0);
    check("R7", "low pin requests", irq_valid, 1);
    check("R7", "low pin vector", irq_vector, 1);
    rd(2'd1, d); check("R7", "no stored flag", d, 8'h00);
    set_pin(1'b1);
    check("R7", "request ends with pin high", irq_valid, 0);
    rd(2'd1, d); check("R7", "still no flag", d, 8'h00);
  endtask

  task automatic t_set_wins();
    logic [7:0] d;
    @(negedge clk);
    src_req = 3'b010; bus_wr = 1'b1; bus_addr = 2'd1; bus_wdata = 8'h02;
    @(negedge clk);
    src_req = '0; bus_wr = 1'b0;
    rd(2'd1, d); check("R10", "set beats clear", d, 8'h02);
    wr(2'd1, 8'h02);
  endtask

  task automatic t_reserved();
    logic [7:0] d;
    wr(2'd0, 8'hFF);
    rd(2'd0, d); check("R8", "mask reserved bits", d, 8'h47);
    wr(2'd0, 8'h00);
    pulse(3'b100);
    rd(2'd1, d); check("R8", "source 3 at bit 2", d, 8'h04);
    wr(2'd1, 8'hFF);
    rd(2'd1, d); check("R8", "flags cleared", d, 8'h00);
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_masked_latch();
    t_priority();
    t_edges();
    t_level();
    t_set_wins();
    t_reserved();
    finish_run();
  end

endmodule